// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block turns the control fields of a clock generator into one registered operating mode and the enables that go with it. The generator has a frequency-locked loop (FLL) and an external reference path. From a 2-bit source-select field, a reference-select bit, a low-power bit, a debug-active flag and a stop request, the controller picks one of four modes. These are FLL-engaged (the default for every combination that does not bypass), bypassed-external, bypassed-external low-power, and halted. It then drives the FLL enable, the external reference enable and the output clock source select to match.

When the FLL takes its reference from outside, the controller also checks the chosen divider and range against the 31.25 kHz to 39.0625 kHz window the loop expects. It raises a configuration error when the divided frequency falls outside that window. A lock qualifier counts consecutive cycles of the analog lock indication while the FLL is enabled, and only then tells timing-sensitive logic that the output is usable. Any loss of lock, a low-power bypass or a stop throws that qualification away, so after stop the loop has to reacquire from its reset frequency. The analog parts are represented only by the lock input.

Top module: `clkgen_mode_ctl`

## Requirements
- R1: While reset is applied, and until the first decoded change after it, mode is 0 (engaged), fll_en is 1, ext_ref_en is 0, out_sel_ext is 0, lock_valid is 0 and cfg_err is 0.
- R2: With stop_req low, src_sel = 2'b10, ref_int = 0 and (dbg_active = 1 or low_pwr = 0), mode becomes 1 (bypassed-external) with fll_en = 1, ext_ref_en = 1 and out_sel_ext = 1.
- R3: With stop_req low, src_sel = 2'b10, ref_int = 0, dbg_active = 0 and low_pwr = 1, mode becomes 2 (bypassed-external low-power) with fll_en = 0, ext_ref_en = 1 and out_sel_ext = 1.
- R4: dbg_active = 1 overrides low_pwr = 1, so the bypass case keeps mode 1 and the FLL stays enabled.
- R5: Every other src_sel/ref_int combination with stop_req low gives mode 0, fll_en = 1, out_sel_ext = 0 and ext_ref_en = NOT ref_int.
- R6: stop_req = 1 overrides all other inputs and gives mode 3 (halted) with fll_en = 0, ext_ref_en = 0 and out_sel_ext = 0.
- R7: A change on any decode input shows on mode and the enables exactly one clock edge later, not before.
- R8: lock_valid rises on the ACQ_CYCLES-th consecutive clock edge at which the FLL is enabled and lock_in is high. It falls at the first edge where lock_in is low.
- R9: Any edge with the FLL disabled (low-power bypass or halted) clears the acquisition count. After such a period, a full ACQ_CYCLES edges of lock are needed again before lock_valid rises.
- R10: cfg_err is 1, one edge after the inputs, exactly when the FLL is enabled, fed from the external reference (ext_ref_en = 1), and EXT_REF_HZ / 2^(ref_div + 5*ref_range) lies outside [31250 Hz, 39062.5 Hz], bounds included in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_sel | input | 2 | Output clock source select field; 2'b10 requests external bypass |
| ref_int | input | 1 | FLL reference select: 1 internal, 0 external |
| low_pwr | input | 1 | Low-power request for the bypass case |
| ref_div | input | DIV_W | External reference divider exponent (divide by 2^ref_div) |
| ref_range | input | 1 | High-frequency range: adds a further divide by 32 |
| dbg_active | input | 1 | Debug session active; keeps the FLL running |
| stop_req | input | 1 | System stop request |
| lock_in | input | 1 | Lock indication from the FLL |
| mode | output | 2 | Mode code: 0 engaged, 1 bypass, 2 bypass low-power, 3 halted |
| fll_en | output | 1 | FLL enable |
| ext_ref_en | output | 1 | External reference enable |
| out_sel_ext | output | 1 | Output clock taken from the external reference |
| lock_valid | output | 1 | Lock qualified for timing-sensitive logic |
| cfg_err | output | 1 | Divided external reference outside the FLL window |

## Verification
The bench builds the block with EXT_REF_HZ = 8000000 and ACQ_CYCLES = 8. The 8 MHz reference makes ref_range = 1 with ref_div = 3 land exactly on the 31.25 kHz lower bound, while its neighbours fall on either side of the window, so the inclusive edge and both error sides of R10 are reachable. An acquisition length of 8 keeps the one-short and exact-count lock checks short enough to repeat after loss of lock, after low-power bypass and after stop.

// File: rtl/cgm_pkg.sv
package cgm_pkg;

  typedef enum logic [1:0] {
    CGM_ENGAGED = 2'd0,
    CGM_BYP     = 2'd1,
    CGM_BYP_LP  = 2'd2,
    CGM_HALT    = 2'd3
  } cgm_mode_e;

  typedef struct packed {
    cgm_mode_e mode;
    logic      fll_en;
    logic      ext_en;
    logic      src_ext;
  } cgm_ctl_t;

  localparam logic [1:0] SEL_EXT_BYPASS = 2'b10;

  // FLL input window scaled by 16: 31250*16 and 39062.5*16
  localparam logic [63:0] WIN_LO_X16 = 64'd500000;
  localparam logic [63:0] WIN_HI_X16 = 64'd625000;

  localparam cgm_ctl_t CTL_RESET = '{mode: CGM_ENGAGED, fll_en: 1'b1,
                                     ext_en: 1'b0, src_ext: 1'b0};

endpackage

// File: rtl/cgm_mode_decode.sv
module cgm_mode_decode
  import cgm_pkg::*;
(
  input  logic [1:0] src_sel,
  input  logic       ref_int,
  input  logic       low_pwr,
  input  logic       dbg_active,
  input  logic       stop_req,
  output cgm_ctl_t   ctl
);

  logic bypass_req;
  logic lp_allowed;

  always_comb begin
    bypass_req = (src_sel == SEL_EXT_BYPASS) && !ref_int;
    lp_allowed = low_pwr && !dbg_active;

    ctl = CTL_RESET;
    if (stop_req) begin
      ctl.mode    = CGM_HALT;
      ctl.fll_en  = 1'b0;
      ctl.ext_en  = 1'b0;
      ctl.src_ext = 1'b0;
    end else if (bypass_req && lp_allowed) begin
      ctl.mode    = CGM_BYP_LP;
      ctl.fll_en  = 1'b0;
      ctl.ext_en  = 1'b1;
      ctl.src_ext = 1'b1;
    end else if (bypass_req) begin
      ctl.mode    = CGM_BYP;
      ctl.fll_en  = 1'b1;
      ctl.ext_en  = 1'b1;
      ctl.src_ext = 1'b1;
    end else begin
      ctl.mode    = CGM_ENGAGED;
      ctl.fll_en  = 1'b1;
      ctl.ext_en  = !ref_int;
      ctl.src_ext = 1'b0;
    end
  end

endmodule

// File: rtl/cgm_ref_window.sv
module cgm_ref_window #(
  parameter int unsigned EXT_REF_HZ  = 32768,
  parameter int unsigned DIV_W       = 3,
  parameter int unsigned RANGE_SHIFT = 5
) (
  input  logic [DIV_W-1:0] ref_div,
  input  logic             ref_range,
  output logic             in_window
);

  localparam logic [63:0] BASE_X16 = 64'(EXT_REF_HZ) * 64'd16;

  logic [31:0] shift;
  logic [63:0] scaled;

  always_comb begin
    shift     = 32'(ref_div) + (ref_range ? 32'(RANGE_SHIFT) : 32'd0);
    scaled    = BASE_X16 >> shift;
    in_window = (scaled >= cgm_pkg::WIN_LO_X16) && (scaled <= cgm_pkg::WIN_HI_X16);
  end

endmodule

// File: rtl/cgm_lock_qual.sv
module cgm_lock_qual #(
  parameter int unsigned ACQ_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fll_en_nx,
  input  logic lock_in,
  output logic lock_valid
);

  localparam int unsigned CNT_W = (ACQ_CYCLES > 2) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ACQ_CYCLES - 1);

  logic             count_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;

  always_comb begin
    count_en = fll_en_nx && lock_in;
    if (!count_en)
      cnt_d = '0;
    else if (cnt_q == CNT_TOP)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
    valid_d = count_en && (valid_q || (cnt_q == CNT_TOP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign lock_valid = valid_q;

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> !lock_valid); // R8

  AST_NO_LOCK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fll_en_nx |=> !lock_valid); // R9

endmodule

// File: rtl/clkgen_mode_ctl.sv
module clkgen_mode_ctl
  import cgm_pkg::*;
#(
  parameter int unsigned EXT_REF_HZ  = 32768,
  parameter int unsigned DIV_W       = 3,
  parameter int unsigned RANGE_SHIFT = 5,
  parameter int unsigned ACQ_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic             ref_int,
  input  logic             low_pwr,
  input  logic [DIV_W-1:0] ref_div,
  input  logic             ref_range,
  input  logic             dbg_active,
  input  logic             stop_req,
  input  logic             lock_in,
  output logic [1:0]       mode,
  output logic             fll_en,
  output logic             ext_ref_en,
  output logic             out_sel_ext,
  output logic             lock_valid,
  output logic             cfg_err
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  cgm_ctl_t ctl_d, ctl_q;
  logic     in_window;
  logic     cfg_err_d, cfg_err_q;
  logic     upd_en;

  cgm_mode_decode u_decode (
    .src_sel    (src_sel),
    .ref_int    (ref_int),
    .low_pwr    (low_pwr),
    .dbg_active (dbg_active),
    .stop_req   (stop_req),
    .ctl        (ctl_d)
  );

  cgm_ref_window #(
    .EXT_REF_HZ  (EXT_REF_HZ),
    .DIV_W       (DIV_W),
    .RANGE_SHIFT (RANGE_SHIFT)
  ) u_window (
    .ref_div   (ref_div),
    .ref_range (ref_range),
    .in_window (in_window)
  );

  cgm_lock_qual #(
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .fll_en_nx  (ctl_d.fll_en),
    .lock_in    (lock_in),
    .lock_valid (lock_valid)
  );

  always_comb begin
    cfg_err_d = ctl_d.fll_en && ctl_d.ext_en && !in_window;
    upd_en    = (ctl_d != ctl_q) || (cfg_err_d != cfg_err_q);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q     <= CTL_RESET;
      cfg_err_q <= 1'b0;
    end else if (upd_en) begin
      ctl_q     <= ctl_d;
      cfg_err_q <= cfg_err_d;
    end
  end

  assign mode        = ctl_q.mode;
  assign fll_en      = ctl_q.fll_en;
  assign ext_ref_en  = ctl_q.ext_en;
  assign out_sel_ext = ctl_q.src_ext;
  assign cfg_err     = cfg_err_q;

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    stop_req |=> (mode == 2'd3) && !fll_en && !ext_ref_en && !out_sel_ext); // R6

  AST_BYP_PATH: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == 2'd1) |-> fll_en && ext_ref_en && out_sel_ext); // R2

  AST_LP_FLL_OFF: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == 2'd2) |-> !fll_en && ext_ref_en && out_sel_ext); // R3

  AST_DBG_KEEPS_FLL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stop_req && src_sel == 2'b10 && !ref_int && dbg_active) |=> (mode == 2'd1) && fll_en); // R4

  AST_CFG_NEEDS_FLL: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_err |-> fll_en && ext_ref_en); // R10

  AST_HALT_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == 2'd3) |-> !lock_valid); // R9

endmodule

// File: tb/sim_clkgen_mode_ctl.sv
module sim_clkgen_mode_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned EXT_HZ = 8000000;
  localparam int unsigned ACQ    = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] src_sel;
  logic       ref_int, low_pwr, ref_range, dbg_active, stop_req, lock_in;
  logic [2:0] ref_div;
  logic [1:0] mode;
  logic       fll_en, ext_ref_en, out_sel_ext, lock_valid, cfg_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_mode_ctl #(
    .EXT_REF_HZ (EXT_HZ),
    .DIV_W      (3),
    .RANGE_SHIFT(5),
    .ACQ_CYCLES (ACQ)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ref_int(ref_int),
    .low_pwr(low_pwr), .ref_div(ref_div), .ref_range(ref_range),
    .dbg_active(dbg_active), .stop_req(stop_req), .lock_in(lock_in),
    .mode(mode), .fll_en(fll_en), .ext_ref_en(ext_ref_en),
    .out_sel_ext(out_sel_ext), .lock_valid(lock_valid), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected {mode, fll, ext, srcext} from the requirement table
  function automatic logic [4:0] model(input logic [1:0] s, input logic ri,
                                       input logic lp, input logic dbg, input logic st);
    if (st)                            return {2'd3, 1'b0, 1'b0, 1'b0};
    if (s == 2'b10 && !ri && lp && !dbg) return {2'd2, 1'b0, 1'b1, 1'b0} | 5'b00001;
    if (s == 2'b10 && !ri)             return {2'd1, 1'b1, 1'b1, 1'b1};
    return {2'd0, 1'b1, !ri, 1'b0};
  endfunction

  function automatic bit window_ok(input int dv, input bit rg);
    longint unsigned x;
    x = (longint'(EXT_HZ) * 16) >> (dv + (rg ? 5 : 0));
    return (x >= 500000) && (x <= 625000);
  endfunction

  task automatic drive(input logic [1:0] s, input logic ri, input logic lp,
                       input logic dbg, input logic st);
    src_sel = s; ref_int = ri; low_pwr = lp; dbg_active = dbg; stop_req = st;
  endtask

  task automatic check_ctl(input string req, input logic [4:0] e);
    chk({req, " mode"},  int'(mode),        int'(e[4:3]));
    chk({req, " fll"},   int'(fll_en),      int'(e[2]));
    chk({req, " ext"},   int'(ext_ref_en),  int'(e[1]));
    chk({req, " osel"},  int'(out_sel_ext), int'(e[0]));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    lock_in = 1'b1; ref_div = 3'd7; ref_range = 1'b0;
    repeat (3) @(negedge clk);
    check_ctl("R1 in reset", {2'd0, 1'b1, 1'b0, 1'b0});
    chk("R1 lock_valid", int'(lock_valid), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    drive(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    lock_in = 1'b0; ref_div = 3'd3; ref_range = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_ctl("R1 after release", {2'd0, 1'b1, 1'b0, 1'b0});
    chk("R1 lock_valid after release", int'(lock_valid), 0);
  endtask

  task automatic t_decode_sweep;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] s;
      logic ri, lp, dbg, st;
      logic [4:0] e;
      string tag;
      s = i[1:0]; ri = i[2]; lp = i[3]; dbg = i[4]; st = 1'b0;
      drive(s, ri, lp, dbg, st);
      @(negedge clk);
      e = model(s, ri, lp, dbg, st);
      case (e[4:3])
        2'd1: tag = (dbg && lp) ? "R4 dbg override" : "R2 bypass";
        2'd2: tag = "R3 bypass lp";
        default: tag = "R5 other";
      endcase
      check_ctl(tag, e);
      chk("R10 cfg in window", int'(cfg_err), 0);
    end
  endtask

  task automatic t_stop_override;
    for (int i = 0; i < 16; i++) begin
      drive(i[1:0], i[2], i[3], 1'b1, 1'b1);
      @(negedge clk);
      check_ctl("R6 stop", {2'd3, 1'b0, 1'b0, 1'b0});
    end
    drive(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_latency;
    drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R7 before edge mode", int'(mode), 0);
    @(posedge clk); #1;
    chk("R7 after edge mode", int'(mode), 1);
    @(negedge clk);
    drive(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    #1;
    chk("R7 before edge fll", int'(fll_en), 1);
    @(posedge clk); #1;
    chk("R7 after edge fll", int'(fll_en), 0);
    @(negedge clk);
  endtask

  task automatic acquire(input string req);
    repeat (ACQ - 1) @(negedge clk);
    chk({req, " one short"}, int'(lock_valid), 0);
    @(negedge clk);
    chk({req, " full count"}, int'(lock_valid), 1);
  endtask

  task automatic t_lock;
    lock_in = 1'b0;
    drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    lock_in = 1'b1;
    acquire("R8 acquire");
    repeat (3) @(negedge clk);
    chk("R8 stays", int'(lock_valid), 1);
    lock_in = 1'b0;
    @(negedge clk);
    chk("R8 drop", int'(lock_valid), 0);
    lock_in = 1'b1;
    drive(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (ACQ + 2) @(negedge clk);
    chk("R9 lp no lock", int'(lock_valid), 0);
    drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    acquire("R9 after lp");
  endtask

  task automatic t_stop_relock;
    lock_in = 1'b1;
    drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (ACQ + 2) @(negedge clk);
    chk("R8 locked before stop", int'(lock_valid), 1);
    stop_req = 1'b1;
    @(negedge clk);
    chk("R9 stop clears", int'(lock_valid), 0);
    chk("R6 stop mode", int'(mode), 3);
    repeat (3) @(negedge clk);
    stop_req = 1'b0;
    acquire("R9 after stop");
    lock_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_cfg;
    drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int r = 0; r < 2; r++) begin
      for (int d = 0; d < 8; d++) begin
        ref_div = 3'(d); ref_range = r[0];
        @(negedge clk);
        chk("R10 bypass window", int'(cfg_err), window_ok(d, r[0]) ? 0 : 1);
      end
    end
    ref_div = 3'd2; ref_range = 1'b1;
    drive(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10 lp no err", int'(cfg_err), 0);
    drive(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10 internal no err", int'(cfg_err), 0);
    drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10 engaged ext err", int'(cfg_err), 1);
    ref_div = 3'd3;
    @(negedge clk);
    chk("R10 boundary ok", int'(cfg_err), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_decode_sweep();
    t_stop_override();
    t_latency();
    t_lock();
    t_stop_relock();
    t_cfg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule